// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 32-bit memory address from up to three terms: a base register, an index register shifted left by a scale code, and a displacement taken from the request. It holds eight 32-bit general registers, which a simple write port loads. Each request names a base register and an index register, and each of these terms can be switched off on its own. The scale code and the displacement complete the request.

Switching terms off gives the reduced forms. With only the base on and a zero displacement, the address is the register's contents. With the base on, the address is the base plus the displacement. With the base and the index on and a zero displacement, the address is the base plus the scaled index. With both off, the displacement is used unchanged. Only some registers may fill each role. A request that uses a register outside its allowed set is reported as illegal, and no address is produced for it. The result is registered and comes out one clock after the request, together with a single-cycle valid pulse.

Top module: `ea_addr_gen`

## Requirements
- R1: After reset is released, all eight registers read as zero, and addr_o, addr_valid_o and illegal_o are all 0.
- R2: When wr_en_i is high at a rising clock edge, wr_data_i is stored in the register numbered wr_sel_i (0 to 7). Later requests see the new value.
- R3: For a legal request with req_i high, addr_o equals base + (index << scale) + disp on the next edge. addr_valid_o is high for that one cycle only.
- R4: The scale code scale_i selects the index multiplier: 2'b00 gives x1, 2'b01 gives x2, 2'b10 gives x4 and 2'b11 gives x8. The multiplier is applied as a left shift of 0 to 3 bits.
- R5: When base_en_i = 0 and idx_en_i = 0, the address is disp_i unchanged (direct form).
- R6: When only base_en_i = 1, the address is the base register plus disp_i. With disp_i = 0 this is the register's contents (register direct form).
- R7: When base_en_i = 1, idx_en_i = 1 and disp_i = 0, the address is the base plus the scaled index. With the base off and the index on, the address is the scaled index plus disp_i.
- R8: The base register must be a selector from 0 to 5, and the index register must be selector 6 or 7. If an enabled term breaks its rule, illegal_o is high for one cycle after the request, addr_valid_o stays 0 and addr_o keeps its previous value.
- R9: The selector of a disabled term is not checked. A request whose disabled selectors are out of range is still legal.
- R10: All sums wrap modulo 2^32. There is no overflow indication.
- R11: In a cycle without req_i, the next cycle has addr_valid_o = 0 and illegal_o = 0, and addr_o holds its value.
- R12: A request made in the same cycle as a write to its base register uses the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Number of the register to write |
| wr_data_i | input | 32 | Value to write |
| req_i | input | 1 | Address request strobe |
| base_en_i | input | 1 | Base term enable |
| base_sel_i | input | 3 | Base register selector |
| idx_en_i | input | 1 | Index term enable |
| idx_sel_i | input | 3 | Index register selector |
| scale_i | input | 2 | Index scale code |
| disp_i | input | 32 | Displacement |
| addr_o | output | 32 | Computed address |
| addr_valid_o | output | 1 | Address valid pulse |
| illegal_o | output | 1 | Illegal register choice pulse |

## Verification
Each request result (addr_o with addr_valid_o, or illegal_o) is due exactly one clock after the edge that samples the request. A register write shows up at the edge where it is made, so a request issued one cycle later can observe it. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which lies half a period after the result edge. It then samples again one cycle later to confirm that the pulses have dropped and that addr_o has held.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    SC_X1 = 2'd0,
    SC_X2 = 2'd1,
    SC_X4 = 2'd2,
    SC_X8 = 2'd3
  } scale_e;

  typedef struct packed {
    logic base_on;
    logic idx_on;
  } term_en_t;

endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int DW    = 32,
  parameter int NREGS = 8,
  localparam int SELW = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [SELW-1:0] wr_sel_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [SELW-1:0] rd_a_sel_i,
  input  logic [SELW-1:0] rd_b_sel_i,
  output logic [DW-1:0]   rd_a_o,
  output logic [DW-1:0]   rd_b_o
);

  logic [NREGS-1:0][DW-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NREGS; i++) begin
        if (wr_sel_i == SELW'(i)) regs_q[i] <= wr_data_i;
      end
    end
  end

  // reads come from flops, so a same-cycle write is not seen
  assign rd_a_o = regs_q[rd_a_sel_i];
  assign rd_b_o = regs_q[rd_b_sel_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_q[$past(wr_sel_i)] == $past(wr_data_i)); // R2

endmodule

// File: rtl/ea_sel_check.sv
module ea_sel_check #(
  parameter int NREGS = 8,
  parameter logic [NREGS-1:0] BASE_OK_MASK = 8'h3F,
  parameter logic [NREGS-1:0] IDX_OK_MASK  = 8'hC0,
  localparam int SELW = $clog2(NREGS)
) (
  input  ea_pkg::term_en_t en_i,
  input  logic [SELW-1:0]  base_sel_i,
  input  logic [SELW-1:0]  idx_sel_i,
  output logic             legal_o
);

  logic base_ok, idx_ok;

  // disabled terms are not checked
  assign base_ok = !en_i.base_on || BASE_OK_MASK[base_sel_i];
  assign idx_ok  = !en_i.idx_on  || IDX_OK_MASK[idx_sel_i];
  assign legal_o = base_ok && idx_ok;

endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
  parameter int DW = 32
) (
  input  ea_pkg::term_en_t en_i,
  input  logic [DW-1:0]    base_i,
  input  logic [DW-1:0]    idx_i,
  input  ea_pkg::scale_e   scale_i,
  input  logic [DW-1:0]    disp_i,
  output logic [DW-1:0]    sum_o
);
  import ea_pkg::*;

  logic [DW-1:0] base_term, idx_raw, idx_term;

  assign base_term = en_i.base_on ? base_i : '0;
  assign idx_raw   = en_i.idx_on  ? idx_i  : '0;

  always_comb begin
    unique case (scale_i)
      SC_X1:   idx_term = idx_raw;
      SC_X2:   idx_term = {idx_raw[DW-2:0], 1'b0};
      SC_X4:   idx_term = {idx_raw[DW-3:0], 2'b0};
      default: idx_term = {idx_raw[DW-4:0], 3'b0};
    endcase
  end

  // single path, carries out of the top bit are dropped
  assign sum_o = base_term + idx_term + disp_i;

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen #(
  parameter int DW    = 32,
  parameter int NREGS = 8,
  parameter logic [NREGS-1:0] BASE_OK_MASK = 8'h3F,
  parameter logic [NREGS-1:0] IDX_OK_MASK  = 8'hC0,
  localparam int SELW = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [SELW-1:0] wr_sel_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            req_i,
  input  logic            base_en_i,
  input  logic [SELW-1:0] base_sel_i,
  input  logic            idx_en_i,
  input  logic [SELW-1:0] idx_sel_i,
  input  logic [1:0]      scale_i,
  input  logic [DW-1:0]   disp_i,
  output logic [DW-1:0]   addr_o,
  output logic            addr_valid_o,
  output logic            illegal_o
);
  import ea_pkg::*;

  term_en_t      en;
  logic [DW-1:0] base_val, idx_val, sum;
  logic          legal;
  logic [DW-1:0] addr_q;
  logic          valid_q, ill_q;

  assign en.base_on = base_en_i;
  assign en.idx_on  = idx_en_i;

  ea_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .rd_a_sel_i (base_sel_i),
    .rd_b_sel_i (idx_sel_i),
    .rd_a_o     (base_val),
    .rd_b_o     (idx_val)
  );

  ea_sel_check #(
    .NREGS(NREGS), .BASE_OK_MASK(BASE_OK_MASK), .IDX_OK_MASK(IDX_OK_MASK)
  ) u_chk (
    .en_i       (en),
    .base_sel_i (base_sel_i),
    .idx_sel_i  (idx_sel_i),
    .legal_o    (legal)
  );

  ea_sum #(.DW(DW)) u_sum (
    .en_i    (en),
    .base_i  (base_val),
    .idx_i   (idx_val),
    .scale_i (scale_e'(scale_i)),
    .disp_i  (disp_i),
    .sum_o   (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      valid_q <= req_i && legal;
      ill_q   <= req_i && !legal;
      if (req_i && legal) addr_q <= sum;
    end
  end

  assign addr_o       = addr_q;
  assign addr_valid_o = valid_q;
  assign illegal_o    = ill_q;

  AST_VALID_XOR_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_valid_o && illegal_o)); // R8
  AST_PULSE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o || illegal_o) |-> $past(req_i)); // R11
  AST_ADDR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_o |-> $stable(addr_o)); // R11
  AST_DIRECT_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && $past(!base_en_i && !idx_en_i)) |-> addr_o == $past(disp_i)); // R5
  AST_BAD_INDEX_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && idx_en_i && !IDX_OK_MASK[idx_sel_i]) |-> illegal_o); // R8

endmodule

// File: tb/tb_ea_addr_gen.sv
module tb_ea_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        req_i = 1'b0;
  logic        base_en_i = 1'b0;
  logic [2:0]  base_sel_i = '0;
  logic        idx_en_i = 1'b0;
  logic [2:0]  idx_sel_i = '0;
  logic [1:0]  scale_i = '0;
  logic [31:0] disp_i = '0;
  logic [31:0] addr_o;
  logic        addr_valid_o, illegal_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [8];
  logic [31:0] last_addr = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ea_addr_gen dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    wr_en_i = 1'b1; wr_sel_i = 3'(sel); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model[sel] = d;
  endtask

  // drive request, one edge later the result is on the outputs
  task automatic issue(input logic be, input int bs, input logic ie, input int is,
                       input int sc, input logic [31:0] d);
    req_i = 1'b1; base_en_i = be; base_sel_i = 3'(bs);
    idx_en_i = ie; idx_sel_i = 3'(is); scale_i = 2'(sc); disp_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  function automatic logic [31:0] ea(input logic be, input int bs, input logic ie,
                                     input int is, input int sc, input logic [31:0] d);
    logic [31:0] b, x;
    b = be ? model[bs] : 32'h0;
    x = ie ? (model[is] << sc) : 32'h0;
    return b + x + d;
  endfunction

  task automatic expect_ok(input string tag, input logic [31:0] exp);
    chk({tag, " valid"}, 32'(addr_valid_o), 32'd1);
    chk({tag, " illegal"}, 32'(illegal_o), 32'd0);
    chk({tag, " addr"}, addr_o, exp);
    last_addr = exp;
  endtask

  task automatic t_reset;
    chk("R1 addr", addr_o, 32'h0);
    chk("R1 valid", 32'(addr_valid_o), 32'd0);
    chk("R1 illegal", 32'(illegal_o), 32'd0);
    for (int r = 0; r < 6; r++) begin
      issue(1, r, 0, 0, 0, 32'h0);
      expect_ok("R1 base reg zero", 32'h0);
    end
    issue(0, 0, 1, 7, 0, 32'h0);
    expect_ok("R1 index reg zero", 32'h0);
  endtask

  task automatic t_write_and_regdirect;
    wr(0, 32'h1000_0000); wr(1, 32'h0000_1234); wr(2, 32'hCAFE_0000);
    wr(3, 32'h0000_00FF); wr(4, 32'h7FFF_FFF0); wr(5, 32'h0BAD_F00D);
    wr(6, 32'h0000_0010); wr(7, 32'h0000_0003);
    for (int r = 0; r < 6; r++) begin
      issue(1, r, 0, 0, 0, 32'h0);
      expect_ok("R2 R6 register direct", model[r]);
    end
    issue(1, 5, 0, 0, 0, 32'h0000_0100);
    expect_ok("R6 base plus disp", ea(1, 5, 0, 0, 0, 32'h100));
    issue(1, 5, 0, 0, 0, 32'hFFFF_FFFC);
    expect_ok("R6 negative disp", ea(1, 5, 0, 0, 0, 32'hFFFF_FFFC));
  endtask

  task automatic t_full_scales;
    for (int sc = 0; sc < 4; sc++) begin
      issue(1, 1, 1, 6, sc, 32'h50);
      expect_ok("R3 R4 full form idx6", ea(1, 1, 1, 6, sc, 32'h50));
      issue(1, 3, 1, 7, sc, 32'h0);
      expect_ok("R4 scale idx7", 32'h0000_00FF + (32'd3 << sc));
    end
    @(negedge clk_i);
    chk("R3 valid is a one-cycle pulse", 32'(addr_valid_o), 32'd0);
  endtask

  task automatic t_direct_and_partial;
    issue(0, 2, 0, 6, 3, 32'hDEAD_BEEF);
    expect_ok("R5 direct form", 32'hDEAD_BEEF);
    issue(1, 0, 1, 6, 1, 32'h0);
    expect_ok("R7 base plus index", ea(1, 0, 1, 6, 1, 32'h0));
    issue(0, 0, 1, 7, 2, 32'h44);
    expect_ok("R7 index plus disp", ea(0, 0, 1, 7, 2, 32'h44));
  endtask

  task automatic t_illegal;
    issue(1, 1, 1, 2, 0, 32'h8);
    chk("R8 bad index illegal", 32'(illegal_o), 32'd1);
    chk("R8 bad index no valid", 32'(addr_valid_o), 32'd0);
    chk("R8 bad index addr held", addr_o, last_addr);
    issue(1, 6, 0, 0, 0, 32'h8);
    chk("R8 bad base illegal", 32'(illegal_o), 32'd1);
    chk("R8 bad base addr held", addr_o, last_addr);
    issue(1, 7, 1, 6, 0, 32'h8);
    chk("R8 base 7 illegal", 32'(illegal_o), 32'd1);
    @(negedge clk_i);
    chk("R8 illegal lasts one cycle", 32'(illegal_o), 32'd0);
    chk("R8 addr still held", addr_o, last_addr);
  endtask

  task automatic t_disabled_not_checked;
    issue(0, 7, 0, 3, 0, 32'h0000_ABCD);
    expect_ok("R9 disabled selectors ignored", 32'h0000_ABCD);
    issue(1, 2, 0, 1, 2, 32'h1);
    expect_ok("R9 disabled index sel ignored", ea(1, 2, 0, 0, 0, 32'h1));
  endtask

  task automatic t_wrap;
    wr(4, 32'hFFFF_FFF0);
    wr(7, 32'h8000_0001);
    issue(1, 4, 1, 7, 3, 32'h0000_0020);
    expect_ok("R10 wraps modulo 2^32", 32'h0000_0018);
  endtask

  task automatic t_idle;
    repeat (3) begin
      @(negedge clk_i);
      chk("R11 idle no valid", 32'(addr_valid_o), 32'd0);
      chk("R11 idle no illegal", 32'(illegal_o), 32'd0);
      chk("R11 idle addr holds", addr_o, last_addr);
    end
  endtask

  task automatic t_same_cycle;
    logic [31:0] old_v;
    old_v = model[2];
    wr_en_i = 1'b1; wr_sel_i = 3'd2; wr_data_i = 32'h1357_9BDF;
    req_i = 1'b1; base_en_i = 1'b1; base_sel_i = 3'd2;
    idx_en_i = 1'b0; scale_i = 2'd0; disp_i = 32'h0;
    @(negedge clk_i);
    wr_en_i = 1'b0; req_i = 1'b0;
    model[2] = 32'h1357_9BDF;
    expect_ok("R12 same-cycle request sees old value", old_v);
    issue(1, 2, 0, 0, 0, 32'h0);
    expect_ok("R12 next request sees new value", 32'h1357_9BDF);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) model[r] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_write_and_regdirect();
    t_full_scales();
    t_direct_and_partial();
    t_illegal();
    t_disabled_not_checked();
    t_wrap();
    t_idle();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule